// File: doc/BRIEF.md
# Split Status-Flag Register Bank

This block keeps a processor's condition flags as four separate registers instead of one packed status word: a two-bit sign/zero pair, a carry bit, an overflow bit and a four-bit lane-compare group. Each group has its own write enable and data. An instruction that updates only the sign/zero pair therefore writes only that register and does not have to wait on the carry or overflow producers. A fifth register holds the rest of the status word, with every flag position forced to zero.

Two wide writes feed the bank alongside the group ports. A full status-word write fills the base register and all four flag groups from their fields in one cycle. A floating-point status transfer loads sign/zero, carry and overflow from the top nibble of a supplied floating-point status word and leaves the lane-compare group alone. Two outputs read the bank back. The first is the assembled 32-bit word, used for exception save. The second is the same word with the bits a move-from-status operation may not see cleared.

Each flag register picks its next value from four named sources: HOLD, GROUP, FP and WORD. The choice is made with a fixed priority: WORD wins over FP, FP wins over GROUP, and HOLD applies when no write is enabled.

Top module: `status_flag_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the base register and all four flag groups, so both outputs read 0.
- R2: In `status_word`, sign/zero sits in bits 31:30 (sign at 31, zero at 30), carry in bit 29, overflow in bit 28, and the lane-compare group in bits 19:16. All other bits come from the base register.
- R3: The base register stores the written word ANDed with the inverse of 0xF00F0000. After a full-word write with no other write pending, `status_word` equals the written word.
- R4: A full-word write loads sign/zero from bits 31:30, carry from bit 29, overflow from bit 28 and the lane-compare group from bits 19:16, all at the same edge.
- R5: A group write changes only its own group. The other flags and the base are unchanged.
- R6: A sign/zero-only update leaves carry and overflow unchanged.
- R7: A floating-point transfer loads sign/zero from `fp_wd[31:30]`, carry from `fp_wd[29]` and overflow from `fp_wd[28]`, and leaves the lane-compare group unchanged.
- R8: When a full-word write coincides with any group write or a floating-point transfer, the full-word write alone decides every register.
- R9: When a floating-point transfer coincides with sign/zero, carry or overflow group writes, the transfer decides those three groups. A lane-compare write in the same cycle still takes effect.
- R10: `read_word` equals `status_word` ANDed with 0xF8FF03DF.
- R11: Both outputs are combinational from the registers. They reflect writes taken at the previous edge and stay unchanged in any cycle with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nz_we | input | 1 | Sign/zero group write enable |
| nz_wd | input | 2 | Sign/zero write data (bit 1 sign, bit 0 zero) |
| c_we | input | 1 | Carry write enable |
| c_wd | input | 1 | Carry write data |
| v_we | input | 1 | Overflow write enable |
| v_wd | input | 1 | Overflow write data |
| ge_we | input | 1 | Lane-compare group write enable |
| ge_wd | input | 4 | Lane-compare write data |
| word_we | input | 1 | Full status-word write enable |
| word_wd | input | 32 | Full status-word write data |
| fp_we | input | 1 | Floating-point status transfer enable |
| fp_wd | input | 32 | Floating-point status word |
| nz_q | output | 2 | Current sign/zero pair |
| c_q | output | 1 | Current carry |
| v_q | output | 1 | Current overflow |
| ge_q | output | 4 | Current lane-compare group |
| status_word | output | 32 | Assembled status word |
| read_word | output | 32 | Assembled word with the move-from-status mask applied |

## Verification
Full-word writes use all-ones, a mixed pattern and alternating patterns. Together these show whether each field lands at its own bit position and whether the flag positions are wrongly kept in the base register. Single-group writes start from a full-ones state and then from a cleared state, which separates a correct per-group enable from one that disturbs a neighbouring group. Writes made in the same cycle cover WORD against every other source and FP against the three groups it shares. An FP transfer together with a lane-compare write shows that FP does not suppress the lane-compare port. Idle cycles after a write confirm that HOLD keeps every register unchanged.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
    localparam int WORD_W  = 32;
    localparam int NZ_W    = 2;
    localparam int GE_W    = 4;
    localparam int NZ_LO   = 30;
    localparam int C_POS   = 29;
    localparam int V_POS   = 28;
    localparam int GE_LO   = 16;
    localparam logic [WORD_W-1:0] FLAG_MASK = 32'hF00F0000;
    localparam logic [WORD_W-1:0] READ_MASK = 32'hF8FF03DF;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_GROUP = 2'd1,
        SRC_FP    = 2'd2,
        SRC_WORD  = 2'd3
    } src_e;

    function automatic src_e pick_src(input logic word_we, input logic fp_hit,
                                      input logic grp_we);
        if (word_we)     return SRC_WORD;
        else if (fp_hit) return SRC_FP;
        else if (grp_we) return SRC_GROUP;
        else             return SRC_HOLD;
    endfunction
endpackage

// File: rtl/sfb_field_reg.sv
module sfb_field_reg
    import sfb_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  src_e         sel,
    input  logic [W-1:0] grp_d,
    input  logic [W-1:0] fp_d,
    input  logic [W-1:0] word_d,
    output logic [W-1:0] q
);
    logic [W-1:0] nxt;

    always_comb begin
        unique case (sel)
            SRC_HOLD:  nxt = q;
            SRC_GROUP: nxt = grp_d;
            SRC_FP:    nxt = fp_d;
            SRC_WORD:  nxt = word_d;
            default:   nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/sfb_pack.sv
module sfb_pack
    import sfb_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [NZ_W-1:0]   nz,
    input  logic              c,
    input  logic              v,
    input  logic [GE_W-1:0]   ge,
    output logic [WORD_W-1:0] full,
    output logic [WORD_W-1:0] visible
);
    always_comb begin
        full = base & ~FLAG_MASK;
        full[NZ_LO +: NZ_W] = nz;
        full[C_POS]         = c;
        full[V_POS]         = v;
        full[GE_LO +: GE_W] = ge;
        visible = full & READ_MASK;
    end
endmodule

// File: rtl/status_flag_bank.sv
module status_flag_bank
    import sfb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        nz_we,
    input  logic [1:0]  nz_wd,
    input  logic        c_we,
    input  logic        c_wd,
    input  logic        v_we,
    input  logic        v_wd,
    input  logic        ge_we,
    input  logic [3:0]  ge_wd,
    input  logic        word_we,
    input  logic [31:0] word_wd,
    input  logic        fp_we,
    input  logic [31:0] fp_wd,
    output logic [1:0]  nz_q,
    output logic        c_q,
    output logic        v_q,
    output logic [3:0]  ge_q,
    output logic [31:0] status_word,
    output logic [31:0] read_word
);
    src_e nz_sel, c_sel, v_sel, ge_sel;
    logic [WORD_W-1:0] base_q;

    always_comb begin
        nz_sel = pick_src(word_we, fp_we, nz_we);
        c_sel  = pick_src(word_we, fp_we, c_we);
        v_sel  = pick_src(word_we, fp_we, v_we);
        ge_sel = pick_src(word_we, 1'b0,  ge_we);
    end

    sfb_field_reg #(.W(NZ_W)) u_nz (
        .clk(clk), .rst(rst), .sel(nz_sel),
        .grp_d(nz_wd), .fp_d(fp_wd[NZ_LO +: NZ_W]), .word_d(word_wd[NZ_LO +: NZ_W]),
        .q(nz_q)
    );

    sfb_field_reg #(.W(1)) u_c (
        .clk(clk), .rst(rst), .sel(c_sel),
        .grp_d(c_wd), .fp_d(fp_wd[C_POS]), .word_d(word_wd[C_POS]),
        .q(c_q)
    );

    sfb_field_reg #(.W(1)) u_v (
        .clk(clk), .rst(rst), .sel(v_sel),
        .grp_d(v_wd), .fp_d(fp_wd[V_POS]), .word_d(word_wd[V_POS]),
        .q(v_q)
    );

    sfb_field_reg #(.W(GE_W)) u_ge (
        .clk(clk), .rst(rst), .sel(ge_sel),
        .grp_d(ge_wd), .fp_d('0), .word_d(word_wd[GE_LO +: GE_W]),
        .q(ge_q)
    );

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (word_we) base_q <= word_wd & ~FLAG_MASK;
    end

    sfb_pack u_pack (
        .base(base_q), .nz(nz_q), .c(c_q), .v(v_q), .ge(ge_q),
        .full(status_word), .visible(read_word)
    );
endmodule

// File: rtl/sfb_chk.sv
module sfb_chk (
    input logic        clk,
    input logic        rst,
    input logic        nz_we,
    input logic        c_we,
    input logic        v_we,
    input logic        ge_we,
    input logic        word_we,
    input logic [31:0] word_wd,
    input logic        fp_we,
    input logic [31:0] fp_wd,
    input logic [1:0]  nz_q,
    input logic        c_q,
    input logic        v_q,
    input logic [3:0]  ge_q,
    input logic [31:0] status_word
);
    // R3
    word_readback_chk: assert property (@(posedge clk) disable iff (rst)
        word_we |=> status_word == $past(word_wd));

    // R6
    nz_only_chk: assert property (@(posedge clk) disable iff (rst)
        (nz_we && !c_we && !v_we && !word_we && !fp_we) |=> ($stable(c_q) && $stable(v_q)));

    // R7
    fp_load_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_we && !word_we) |=> (nz_q == $past(fp_wd[31:30]) && c_q == $past(fp_wd[29])
                                 && v_q == $past(fp_wd[28])));

    // R7
    fp_keeps_ge_chk: assert property (@(posedge clk) disable iff (rst)
        (fp_we && !word_we && !ge_we) |=> $stable(ge_q));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(nz_we || c_we || v_we || ge_we || word_we || fp_we) |=> $stable(status_word));
endmodule

bind status_flag_bank sfb_chk u_chk (
    .clk(clk), .rst(rst), .nz_we(nz_we), .c_we(c_we), .v_we(v_we), .ge_we(ge_we),
    .word_we(word_we), .word_wd(word_wd), .fp_we(fp_we), .fp_wd(fp_wd),
    .nz_q(nz_q), .c_q(c_q), .v_q(v_q), .ge_q(ge_q), .status_word(status_word)
);

// File: tb/status_flag_bank_tb.sv
module status_flag_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nz_we = 0, c_we = 0, v_we = 0, ge_we = 0, word_we = 0, fp_we = 0;
    logic [1:0]  nz_wd = 0;
    logic        c_wd = 0, v_wd = 0;
    logic [3:0]  ge_wd = 0;
    logic [31:0] word_wd = 0, fp_wd = 0;
    logic [1:0]  nz_q;
    logic        c_q, v_q;
    logic [3:0]  ge_q;
    logic [31:0] status_word, read_word;

    int checks = 0;
    int errors = 0;

    // expected model state
    logic [31:0] e_base;
    logic [1:0]  e_nz;
    logic        e_c, e_v;
    logic [3:0]  e_ge;

    always #4 clk = ~clk;

    status_flag_bank u_dut (
        .clk(clk), .rst(rst),
        .nz_we(nz_we), .nz_wd(nz_wd), .c_we(c_we), .c_wd(c_wd),
        .v_we(v_we), .v_wd(v_wd), .ge_we(ge_we), .ge_wd(ge_wd),
        .word_we(word_we), .word_wd(word_wd), .fp_we(fp_we), .fp_wd(fp_wd),
        .nz_q(nz_q), .c_q(c_q), .v_q(v_q), .ge_q(ge_q),
        .status_word(status_word), .read_word(read_word)
    );

    function automatic logic [31:0] exp_word();
        return {e_nz, e_c, e_v, e_base[27:20], e_ge, e_base[15:0]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, status_word, exp_word());
        chk(req, {26'd0, nz_q, c_q, v_q, ge_q}, {26'd0, e_nz, e_c, e_v, e_ge});
        chk({req, " R10"}, read_word, exp_word() & 32'hF8FF03DF);
    endtask

    task automatic idle();
        nz_we = 0; c_we = 0; v_we = 0; ge_we = 0; word_we = 0; fp_we = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic put_word(input logic [31:0] w);
        word_we = 1; word_wd = w;
        tick();
        e_base = w & ~32'hF00F0000;
        e_nz = w[31:30]; e_c = w[29]; e_v = w[28]; e_ge = w[19:16];
    endtask

    task automatic t_reset();
        rst = 1;
        tick(); tick();
        rst = 0;
        e_base = 0; e_nz = 0; e_c = 0; e_v = 0; e_ge = 0;
        chk("R1 status", status_word, 32'h0);
        chk("R1 read", read_word, 32'h0);
    endtask

    task automatic t_word();
        logic [31:0] pats [3] = '{32'hFFFFFFFF, 32'h12345678, 32'hA5A5A5A5};
        foreach (pats[i]) begin
            put_word(pats[i]);
            chk("R3 readback", status_word, pats[i]);
            chk_all("R4 R2 word fields");
        end
    endtask

    task automatic t_groups();
        put_word(32'hFFFFFFFF);
        nz_we = 1; nz_wd = 2'b01; tick(); e_nz = 2'b01;
        chk_all("R5 R6 nz only");
        c_we = 1; c_wd = 0; tick(); e_c = 0;
        chk_all("R5 carry only");
        v_we = 1; v_wd = 0; tick(); e_v = 0;
        chk_all("R5 overflow only");
        ge_we = 1; ge_wd = 4'h9; tick(); e_ge = 4'h9;
        chk_all("R5 ge only");
        put_word(32'h0);
        nz_we = 1; nz_wd = 2'b10; tick(); e_nz = 2'b10;
        chk_all("R6 nz from zero");
    endtask

    task automatic t_fp();
        put_word(32'h000A0000);
        fp_we = 1; fp_wd = 32'hB0000000; tick();
        e_nz = 2'b10; e_c = 1; e_v = 1;
        chk_all("R7 fp load keeps ge");
        fp_we = 1; fp_wd = 32'h4FFFFFFF;
        nz_we = 1; nz_wd = 2'b11; c_we = 1; c_wd = 1; v_we = 1; v_wd = 1;
        ge_we = 1; ge_wd = 4'h3;
        tick();
        e_nz = 2'b01; e_c = 0; e_v = 0; e_ge = 4'h3;
        chk_all("R9 fp over groups, ge still taken");
    endtask

    task automatic t_prio_word();
        put_word(32'h0);
        word_we = 1; word_wd = 32'h5A0C1234;
        nz_we = 1; nz_wd = 2'b11; c_we = 1; c_wd = 1; v_we = 1; v_wd = 0;
        ge_we = 1; ge_wd = 4'hF; fp_we = 1; fp_wd = 32'hF0000000;
        tick();
        e_base = 32'h5A0C1234 & ~32'hF00F0000;
        e_nz = 2'b01; e_c = 0; e_v = 1; e_ge = 4'hC;
        chk("R8 word wins", status_word, 32'h5A0C1234);
        chk_all("R8 word wins fields");
    endtask

    task automatic t_hold();
        put_word(32'hC3F50F0F);
        tick(); tick();
        chk("R11 hold", status_word, 32'hC3F50F0F);
        chk("R10 R11 read hold", read_word, 32'hC3F50F0F & 32'hF8FF03DF);
    endtask

    initial begin
        idle();
        t_reset();
        t_word();
        t_groups();
        t_fp();
        t_prio_word();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule